// File: doc/BRIEF.md
# Processor Liveness Recovery Monitor

This block lives beside the memory controller of a node and watches whether the local processor is still running. At a fixed interval it sends a one-cycle query strobe to whichever processor is active. It then opens a bounded reply window. If no reply arrives before the window closes, the block declares a fault.

On a fault the block picks a reset target. A fault it judges transient restarts the local processor. A fault it judges permanent moves the node onto the spare processor module for good. The chosen reset line is held for a fixed number of cycles. When the reset is released, a single-cycle recovery-start pulse tells the restarted processor to resume from the last checkpoint. The query schedule then begins again from the start.

Cycle numbering below counts from 0 for the first clock cycle in which the period counter runs. That is the first cycle after `rst_n` rises, or the first cycle after a recovery pulse.

Top module: `liveness_recovery_monitor`

## Requirements
- R1: The query strobe is one cycle wide and goes to the active processor (the local one until a spare is chosen). It is raised in cycle PERIOD-1 and every PERIOD cycles after that, while no fault handling is in progress.
- R2: A reply counts only in the TIMEOUT cycles that directly follow a strobe. A reply in the strobe cycle itself, or outside any window, has no effect.
- R3: If a window passes without a reply, the fault is taken in the window's last cycle. A reset line rises in the next cycle.
- R4: A transient fault holds `rst_local_o` high for exactly RST_LEN cycles.
- R5: If `perm_fault_i` is high in the cycle the fault is taken, the fault counts as permanent and the spare is reset. A high `perm_fault_i` in any other cycle has no effect.
- R6: A timeout counts as permanent when the local processor has been reset and no reply has been accepted since that reset.
- R7: An accepted reply clears the memory of an earlier local reset. The next timeout is then treated as transient again.
- R8: Once the spare is chosen, every later strobe and every reset goes to the spare, until `rst_n` is asserted.
- R9: `recover_start_o` is high for exactly one cycle: the cycle after the reset line falls. The period count restarts from 0 in the following cycle.
- R10: Both reset lines are never high together, and no strobe is raised while a reset or the recovery pulse is active. While `rst_n` is low, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alive_ack_i | input | 1 | Reply from the active processor |
| perm_fault_i | input | 1 | Marks the current fault as permanent |
| query_local_o | output | 1 | Query strobe to the local processor |
| query_spare_o | output | 1 | Query strobe to the spare processor module |
| rst_local_o | output | 1 | Reset to the local processor |
| rst_spare_o | output | 1 | Reset to the spare processor module |
| recover_start_o | output | 1 | One-cycle start of rollback to the last checkpoint |

## Verification
Some behaviours are checked by the assertions on every cycle:
- the two reset lines are never high together;
- no strobe is raised during a reset or the recovery pulse;
- a reset always follows a timeout, and holds for exactly RST_LEN cycles;
- the recovery pulse lasts one cycle and comes only just after a reset;
- spare selection never reverts.

Other behaviours can only be shown by the bench's scenarios:
- the exact cycle of each strobe;
- which edge of the reply window still accepts a reply;
- when a late or early reply, or a stray `perm_fault_i` pulse, is ignored;
- the choice of target after a repeated timeout, and after a reply in between.

// File: rtl/lrm_pkg.sv
package lrm_pkg;

  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_HOLD    = 2'd1,
    ST_RECOVER = 2'd2
  } lrm_state_e;

  // Width of a counter that must hold values 0..limit
  function automatic int cnt_width(input int limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

  // Decide whether a fault moves the node onto the spare module
  function automatic logic go_spare(input logic on_spare,
                                    input logic ext_perm,
                                    input logic strike);
    return on_spare | ext_perm | strike;
  endfunction

endpackage

// File: rtl/lrm_beat_gen.sv
module lrm_beat_gen #(
  parameter int PERIOD = 64,
  localparam int CW = lrm_pkg::cnt_width(PERIOD)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic beat_o
);

  logic [CW-1:0] pcnt_q;

  assign beat_o = run_i && (pcnt_q == CW'(PERIOD - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)       pcnt_q <= '0;
    else if (!run_i)  pcnt_q <= '0;
    else if (beat_o)  pcnt_q <= '0;
    else              pcnt_q <= pcnt_q + 1'b1;
  end

endmodule

// File: rtl/lrm_reply_timer.sv
module lrm_reply_timer #(
  parameter int TIMEOUT = 16,
  localparam int TW = lrm_pkg::cnt_width(TIMEOUT)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic beat_i,
  input  logic ack_i,
  output logic waiting_o,
  output logic reply_ok_o,
  output logic timeout_o
);

  logic [TW-1:0] tcnt_q;
  logic          wait_q;

  assign waiting_o  = wait_q;
  assign reply_ok_o = wait_q && ack_i;
  assign timeout_o  = wait_q && !ack_i && (tcnt_q == TW'(TIMEOUT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || !run_i) begin
      wait_q <= 1'b0;
      tcnt_q <= '0;
    end else if (beat_i) begin
      wait_q <= 1'b1;
      tcnt_q <= '0;
    end else if (wait_q) begin
      if (reply_ok_o || timeout_o) wait_q <= 1'b0;
      else                         tcnt_q <= tcnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/lrm_recovery_fsm.sv
module lrm_recovery_fsm #(
  parameter int RST_LEN = 8,
  localparam int HW = lrm_pkg::cnt_width(RST_LEN)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic timeout_i,
  input  logic reply_ok_i,
  input  logic perm_fault_i,
  output logic run_o,
  output logic hold_o,
  output logic recover_o,
  output logic spare_mode_o
);
  import lrm_pkg::*;

  lrm_state_e    st_q;
  logic [HW-1:0] hcnt_q;
  logic          spare_q;
  logic          strike_q;
  logic          spare_next;

  assign spare_next   = go_spare(spare_q, perm_fault_i, strike_q);
  assign run_o        = (st_q == ST_RUN);
  assign hold_o       = (st_q == ST_HOLD);
  assign recover_o    = (st_q == ST_RECOVER);
  assign spare_mode_o = spare_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_RUN;
      hcnt_q   <= '0;
      spare_q  <= 1'b0;
      strike_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_RUN: begin
          if (timeout_i) begin
            spare_q  <= spare_next;
            strike_q <= !spare_next;
            hcnt_q   <= '0;
            st_q     <= ST_HOLD;
          end else if (reply_ok_i) begin
            strike_q <= 1'b0;
          end
        end
        ST_HOLD: begin
          if (hcnt_q == HW'(RST_LEN - 1)) st_q <= ST_RECOVER;
          else                             hcnt_q <= hcnt_q + 1'b1;
        end
        ST_RECOVER: st_q <= ST_RUN;
        default:    st_q <= ST_RUN;
      endcase
    end
  end

endmodule

// File: rtl/liveness_recovery_monitor.sv
module liveness_recovery_monitor #(
  parameter int PERIOD  = 64,
  parameter int TIMEOUT = 16,
  parameter int RST_LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic alive_ack_i,
  input  logic perm_fault_i,
  output logic query_local_o,
  output logic query_spare_o,
  output logic rst_local_o,
  output logic rst_spare_o,
  output logic recover_start_o
);

  generate
    if (TIMEOUT >= PERIOD || TIMEOUT < 1 || RST_LEN < 1) begin : g_bad_cfg
      $error("liveness_recovery_monitor: need 1 <= TIMEOUT < PERIOD and RST_LEN >= 1");
    end
  endgenerate

  // Internal events, named for the checker
  logic run_w, hold_w, recover_w, spare_mode_w;
  logic beat_w, waiting_w, reply_ok_w, timeout_w;

  lrm_beat_gen #(.PERIOD(PERIOD)) u_beat (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (run_w),
    .beat_o (beat_w)
  );

  lrm_reply_timer #(.TIMEOUT(TIMEOUT)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_i      (run_w),
    .beat_i     (beat_w),
    .ack_i      (alive_ack_i),
    .waiting_o  (waiting_w),
    .reply_ok_o (reply_ok_w),
    .timeout_o  (timeout_w)
  );

  lrm_recovery_fsm #(.RST_LEN(RST_LEN)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .timeout_i    (timeout_w),
    .reply_ok_i   (reply_ok_w),
    .perm_fault_i (perm_fault_i),
    .run_o        (run_w),
    .hold_o       (hold_w),
    .recover_o    (recover_w),
    .spare_mode_o (spare_mode_w)
  );

  // Route strobes and resets to the active target
  assign query_local_o   = beat_w && !spare_mode_w;
  assign query_spare_o   = beat_w &&  spare_mode_w;
  assign rst_local_o     = hold_w && !spare_mode_w;
  assign rst_spare_o     = hold_w &&  spare_mode_w;
  assign recover_start_o = recover_w;

endmodule

// File: rtl/lrm_checker.sv
module lrm_checker #(
  parameter int RST_LEN = 8
) (
  input logic clk,
  input logic rst_n,
  input logic query_local,
  input logic query_spare,
  input logic rst_local,
  input logic rst_spare,
  input logic recover,
  input logic timeout_evt,
  input logic reply_ok,
  input logic waiting,
  input logic spare_mode
);

  logic        rst_any;
  logic [15:0] hold_len_q;

  assign rst_any = rst_local || rst_spare;

  always_ff @(posedge clk) begin
    if (!rst_n)       hold_len_q <= '0;
    else if (rst_any) hold_len_q <= hold_len_q + 1'b1;
    else              hold_len_q <= '0;
  end

  assert_one_query_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({query_local, query_spare}));

  assert_reply_closes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reply_ok |=> !waiting);

  assert_timeout_resets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_evt |=> rst_any);

  assert_reset_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_any) |-> $past(timeout_evt));

  assert_hold_length_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_any) |-> (hold_len_q == 16'(RST_LEN)));

  assert_spare_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    spare_mode |=> spare_mode);

  assert_spare_no_local_R8: assert property (@(posedge clk) disable iff (!rst_n)
    spare_mode |=> !query_local && !rst_local);

  assert_recover_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    recover |=> !recover);

  assert_recover_after_rst_R9: assert property (@(posedge clk) disable iff (!rst_n)
    recover |-> ($past(rst_any) && !rst_any));

  assert_excl_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(rst_local && rst_spare));

  assert_quiet_in_recovery_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_any || recover) |-> !(query_local || query_spare));

endmodule

bind liveness_recovery_monitor lrm_checker #(.RST_LEN(RST_LEN)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .query_local (query_local_o),
  .query_spare (query_spare_o),
  .rst_local   (rst_local_o),
  .rst_spare   (rst_spare_o),
  .recover     (recover_start_o),
  .timeout_evt (timeout_w),
  .reply_ok    (reply_ok_w),
  .waiting     (waiting_w),
  .spare_mode  (spare_mode_w)
);

// File: tb/sim_liveness_recovery_monitor.sv
module sim_liveness_recovery_monitor;

  localparam int P = 16;
  localparam int T = 6;
  localparam int R = 4;

  localparam int K_QL = 0, K_QS = 1, K_RL_ON = 2, K_RL_OFF = 3,
                 K_RS_ON = 4, K_RS_OFF = 5, K_REC = 6;

  typedef struct {
    int    kind;
    int    cyc;
    string req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ack = 1'b0;
  logic perm = 1'b0;
  logic q_l, q_s, r_l, r_s, rec;

  int   cyc = 0;
  int   n_checks = 0;
  int   n_fail = 0;
  bit   done = 1'b0;
  logic prev_rl = 1'b0, prev_rs = 1'b0;
  exp_t sb[$];

  always #2 clk = ~clk;

  liveness_recovery_monitor #(.PERIOD(P), .TIMEOUT(T), .RST_LEN(R)) u0 (
    .clk             (clk),
    .rst_n           (rst_n),
    .alive_ack_i     (ack),
    .perm_fault_i    (perm),
    .query_local_o   (q_l),
    .query_spare_o   (q_s),
    .rst_local_o     (r_l),
    .rst_spare_o     (r_s),
    .recover_start_o (rec)
  );

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  task automatic expect_ev(input int kind, input int c, input string req);
    exp_t e;
    e.kind = kind; e.cyc = c; e.req = req;
    sb.push_back(e);
  endtask

  task automatic observe(input int kind);
    exp_t e;
    n_checks++;
    if (sb.size() == 0) begin
      n_fail++;
      $display("FAIL R10: unexpected event kind %0d at cycle %0d (expected none)", kind, cyc);
    end else begin
      e = sb.pop_front();
      if (e.kind != kind || e.cyc != cyc) begin
        n_fail++;
        $display("FAIL %s: event kind %0d at cycle %0d, expected kind %0d at cycle %0d",
                 e.req, kind, cyc, e.kind, e.cyc);
      end
    end
  endtask

  // Monitor: pops expected items as the design produces events
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (q_l) observe(K_QL);
      if (q_s) observe(K_QS);
      if (r_l && !prev_rl) observe(K_RL_ON);
      if (!r_l && prev_rl) observe(K_RL_OFF);
      if (r_s && !prev_rs) observe(K_RS_ON);
      if (!r_s && prev_rs) observe(K_RS_OFF);
      if (rec) observe(K_REC);
    end
    prev_rl <= r_l;
    prev_rs <= r_s;
  end

  task automatic wait_cyc(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic pulse_ack(input int t);
    wait_cyc(t);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  task automatic pulse_perm(input int t);
    wait_cyc(t);
    perm = 1'b1;
    @(negedge clk);
    perm = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    n_checks++;
    if ({q_l, q_s, r_l, r_s, rec} !== 5'b0) begin
      n_fail++;
      $display("FAIL R10: outputs in reset %b, expected 00000", {q_l, q_s, r_l, r_s, rec});
    end
    rst_n = 1'b1;
  endtask

  task automatic end_phase(input int t);
    wait_cyc(t);
    n_checks++;
    if (sb.size() != 0) begin
      n_fail++;
      $display("FAIL R1: %0d expected events missing at cycle %0d, expected 0", sb.size(), cyc);
    end
    sb.delete();
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL R1: watchdog expired at cycle %0d, expected completion", cyc);
    done = 1'b1;
    report();
  end

  initial begin
    // Phase 1: periodic queries, window edges, local reset, then repeated timeout to spare
    do_reset();
    expect_ev(K_QL, 15, "R1");
    expect_ev(K_QL, 31, "R1");
    expect_ev(K_QL, 47, "R1");
    expect_ev(K_RL_ON, 54, "R2");     // reply in strobe cycle ignored
    expect_ev(K_RL_OFF, 58, "R4");
    expect_ev(K_REC, 58, "R9");
    expect_ev(K_QL, 74, "R9");
    expect_ev(K_RS_ON, 81, "R6");
    expect_ev(K_RS_OFF, 85, "R6");
    expect_ev(K_REC, 85, "R9");
    expect_ev(K_QS, 101, "R8");
    expect_ev(K_QS, 117, "R8");
    expect_ev(K_RS_ON, 124, "R8");
    expect_ev(K_RS_OFF, 128, "R8");
    expect_ev(K_REC, 128, "R9");
    expect_ev(K_QS, 144, "R8");
    pulse_ack(18);
    pulse_ack(37);                    // last cycle of window, R2
    pulse_ack(47);                    // strobe cycle, R2 ignored
    pulse_ack(103);
    end_phase(150);

    // Phase 2: permanent-fault input only counts in the deadline cycle (R5)
    do_reset();
    expect_ev(K_QL, 15, "R1");
    expect_ev(K_RS_ON, 22, "R5");
    expect_ev(K_RS_OFF, 26, "R5");
    expect_ev(K_REC, 26, "R9");
    expect_ev(K_QS, 42, "R8");
    expect_ev(K_QS, 58, "R8");
    pulse_perm(10);
    pulse_perm(18);
    pulse_perm(21);
    pulse_ack(44);
    end_phase(62);

    // Phase 3: an accepted reply clears the strike (R7)
    do_reset();
    expect_ev(K_QL, 15, "R3");
    expect_ev(K_RL_ON, 22, "R3");
    expect_ev(K_RL_OFF, 26, "R4");
    expect_ev(K_REC, 26, "R9");
    expect_ev(K_QL, 42, "R1");
    expect_ev(K_QL, 58, "R7");
    expect_ev(K_RL_ON, 65, "R7");
    expect_ev(K_RL_OFF, 69, "R7");
    expect_ev(K_REC, 69, "R9");
    expect_ev(K_QL, 85, "R7");
    pulse_ack(43);
    pulse_ack(86);
    end_phase(92);

    done = 1'b1;
    report();
  end

endmodule